// File: doc/BRIEF.md
# Ethernet DMA Control and Interrupt Registers

This block is the software-visible register file of a small Ethernet DMA controller. A host reaches it over a plain 32-bit bus with byte offsets that are word aligned. It holds the pointers to four receive rings and two transmit rings, the interrupt cause and mask words, a port setting that moves received data two bytes into each buffer, and a command word that starts the transmit queues. The receive and transmit engines report finished work through single-cycle pulses. The block turns the masked causes into a level interrupt.

A management word gives the PHY access that a driver expects without any real serial management traffic. Software writes a PHY and register address together with a read opcode. A following read of the same word returns an answer taken from a fixed model: link and autonegotiation status, and a two-half identifier. The read-valid flag is set in each answer.

Top module: `nic_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `irq` is low, `tx_start` is 0, `rx_pad_bytes` is 0 and every ring pointer output is 0.
- R2: The cause word is at 0x450. A write ANDs the written value into the stored cause, so a 0 bit clears and a 1 bit keeps. Software cannot set a cause bit. `ev_rx` sets bit 0, `ev_txq1` sets bit 2 and `ev_txq0` sets bit 3.
- R3: An engine pulse that arrives in the same cycle as a cause write is applied after the AND, so the event is not lost.
- R4: The mask word is at 0x450+8 = 0x458 and reads back as written. `irq` is high exactly while (cause AND mask) is non-zero. It follows the registered state, so it is seen in the cycle after the write or pulse that changes that state, and that includes a mask write.
- R5: The management word is at 0x010. Field layout: data bits 15:0, address bits 25:16, read opcode bit 26, read-valid flag bit 27. When the stored opcode is 1, a read returns 0x0800000C for address 0x021, 0x08000141 for address 0x041 and 0x08000E20 for address 0x061.
- R6: When the stored opcode is 1 and the address is none of those three, a management read returns 0x08000000. When the opcode is 0, it returns 0.
- R7: A write to the command word at 0x448 stores nothing. Bit 23 gives a one-cycle `tx_start[1]` pulse and bit 22 gives a one-cycle `tx_start[0]` pulse, both in the cycle after the write. A read of 0x448 returns 0.
- R8: A write to the port word at 0x408 sets `rx_pad_bytes` to 2 if bit 28 is 1 and to 0 if it is 0. A read of 0x408 returns 0.
- R9: The first-receive pointers are at 0x480+4i (i=0..3), the current-receive pointers at 0x4A0+4i (i=0..3) and the current-transmit pointers at 0x4E0+4i (i=0..1). Each reads back as written and drives bits [32i+31:32i] of its output vector.
- R10: A read of any other offset returns 0. A write to any other offset changes no register and no output.
- R11: `bus_rdata` is loaded at the clock edge where `bus_rd` is high, using the state from before any write in that same cycle. It holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_rx | input | 1 | Receive engine finished a frame |
| ev_txq0 | input | 1 | Transmit queue 0 finished a descriptor |
| ev_txq1 | input | 1 | Transmit queue 1 finished a descriptor |
| irq | output | 1 | Level interrupt |
| tx_start | output | 2 | Start pulses for transmit queues 1:0 |
| rx_pad_bytes | output | 2 | Byte offset for received data (0 or 2) |
| rx_first_ptrs | output | 128 | First-receive ring pointers |
| rx_cur_ptrs | output | 128 | Current-receive ring pointers |
| tx_cur_ptrs | output | 64 | Current-transmit ring pointers |

## Verification
The assertions assume that the engine pulses and bus strobes are synchronous and last exactly one cycle. They also assume that the offset is meaningful only while a strobe is high, and that the register and unmapped checks see word-aligned offsets. The stimulus drives every input on the falling edge, for one cycle at a time, and uses only aligned offsets. It never asserts a read and a write in the same cycle, except where the read-before-write ordering is itself the point under test. Same-cycle collisions between a cause write and an engine pulse are produced on purpose, so the properties on event retention see real traffic.

// File: rtl/nic_regs_pkg.sv
// Shared offsets, field positions and PHY model constants for the
// Ethernet DMA control register block.
package nic_regs_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    // Register offsets (byte addresses)
    localparam logic [ADDR_W-1:0] OFF_MGMT    = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_PORT    = 12'h408;
    localparam logic [ADDR_W-1:0] OFF_CMD     = 12'h448;
    localparam logic [ADDR_W-1:0] OFF_CAUSE   = 12'h450;
    localparam logic [ADDR_W-1:0] OFF_MASK    = 12'h458;
    localparam logic [ADDR_W-1:0] OFF_RXFIRST = 12'h480;
    localparam logic [ADDR_W-1:0] OFF_RXCUR   = 12'h4A0;
    localparam logic [ADDR_W-1:0] OFF_TXCUR   = 12'h4E0;

    // Field positions
    localparam int unsigned MG_OPC_BIT   = 26;
    localparam int unsigned MG_VALID_BIT = 27;
    localparam int unsigned CMD_Q1_BIT   = 23;
    localparam int unsigned CMD_Q0_BIT   = 22;
    localparam int unsigned PORT_PAD_BIT = 28;
    localparam int unsigned CAUSE_RX     = 0;
    localparam int unsigned CAUSE_TXQ1   = 2;
    localparam int unsigned CAUSE_TXQ0   = 3;

    // Canned PHY model
    localparam logic [9:0]  PHY_STAT_ADR = 10'h021;
    localparam logic [9:0]  PHY_ID1_ADR  = 10'h041;
    localparam logic [9:0]  PHY_ID2_ADR  = 10'h061;
    localparam logic [15:0] PHY_STAT_VAL = 16'h000C;
    localparam logic [15:0] PHY_ID1_VAL  = 16'h0141;
    localparam logic [15:0] PHY_ID2_VAL  = 16'h0E20;

    // Decoded write request handed to the sub-blocks
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] off;
        logic [DATA_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/nic_ptr_bank.sv
// Bank of N ring pointer registers at BASE + 4*i.
// Assumes word-aligned offsets; flags a hit for any offset in its window.
module nic_ptr_bank
    import nic_regs_pkg::*;
#(
    parameter int unsigned N    = 4,
    parameter int unsigned BASE = 12'h480
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wr_req_t             wr,
    input  logic [ADDR_W-1:0]   rd_off,
    output logic                rd_hit,
    output logic [DATA_W-1:0]   rd_val,
    output logic [N*DATA_W-1:0] ptrs
);
    localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1;
    localparam int unsigned SPAN = N * 4;

    logic [DATA_W-1:0] regs [N];
    logic [ADDR_W-1:0] wr_rel, rd_rel;
    logic              wr_hit;
    logic [IW-1:0]     wr_idx, rd_idx;

    // Window decode for both the write and the read offset
    always_comb begin
        wr_rel = wr.off - ADDR_W'(BASE);
        rd_rel = rd_off - ADDR_W'(BASE);
        wr_hit = (wr.off >= ADDR_W'(BASE)) && (wr_rel < ADDR_W'(SPAN)) && (wr.off[1:0] == 2'b00);
        rd_hit = (rd_off >= ADDR_W'(BASE)) && (rd_rel < ADDR_W'(SPAN)) && (rd_off[1:0] == 2'b00);
        wr_idx = wr_rel[IW+1:2];
        rd_idx = rd_rel[IW+1:2];
        rd_val = rd_hit ? regs[rd_idx] : '0;
    end

    for (genvar i = 0; i < N; i++) begin : g_ptr
        // One pointer register, loaded when its slot is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr.en && wr_hit && (wr_idx == IW'(i)))
                regs[i] <= wr.data;
        end
        assign ptrs[i*DATA_W +: DATA_W] = regs[i];
    end
endmodule

// File: rtl/nic_cause_ctl.sv
// Interrupt cause and mask with level interrupt.
// Software writes AND into the cause; engine pulses OR in afterwards.
// Assumes engine pulses are synchronous to clk.
module nic_cause_ctl
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cause_wr,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ev_rx,
    input  logic              ev_txq0,
    input  logic              ev_txq1,
    output logic [DATA_W-1:0] cause,
    output logic [DATA_W-1:0] mask,
    output logic              irq
);
    logic [DATA_W-1:0] set_vec, cause_nxt;

    // Build the set vector and the next cause: AND first, then OR
    always_comb begin
        set_vec             = '0;
        set_vec[CAUSE_RX]   = ev_rx;
        set_vec[CAUSE_TXQ1] = ev_txq1;
        set_vec[CAUSE_TXQ0] = ev_txq0;
        cause_nxt           = (cause_wr ? (cause & wdata) : cause) | set_vec;
    end

    // Cause and mask storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
            mask  <= '0;
        end else begin
            cause <= cause_nxt;
            if (mask_wr)
                mask <= wdata;
        end
    end

    // Level interrupt from the stored state
    assign irq = |(cause & mask);

    AST_RX_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx |=> cause[CAUSE_RX]); // R3
    AST_TXQ0_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_txq0 |=> cause[CAUSE_TXQ0]); // R3
    AST_SW_CANNOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_wr && !ev_rx && !ev_txq0 && !ev_txq1) |=> ((cause & ~$past(cause)) == '0)); // R2
endmodule

// File: rtl/nic_mgmt_port.sv
// Management word with a canned PHY responder.
// Holds the last written word; reads are answered from a fixed model.
module nic_mgmt_port
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              opc,
    output logic [DATA_W-1:0] resp
);
    logic [DATA_W-1:0] word_q;
    logic [9:0]        phy_adr;

    // Store the written management word
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (wr)
            word_q <= wdata;
    end

    // Answer from the PHY model when the read opcode is stored
    always_comb begin
        opc     = word_q[MG_OPC_BIT];
        phy_adr = word_q[25:16];
        resp    = '0;
        if (opc) begin
            resp[MG_VALID_BIT] = 1'b1;
            case (phy_adr)
                PHY_STAT_ADR: resp[15:0] = PHY_STAT_VAL;
                PHY_ID1_ADR:  resp[15:0] = PHY_ID1_VAL;
                PHY_ID2_ADR:  resp[15:0] = PHY_ID2_VAL;
                default:      resp[15:0] = '0;
            endcase
        end
    end
endmodule

// File: rtl/nic_ctrl_regs.sv
// Top of the Ethernet DMA control register block: decodes the bus,
// owns the read register, command strobes and port setting, and
// instantiates the cause unit, management port and pointer banks.
// Assumes one-cycle strobes and word-aligned offsets.
module nic_ctrl_regs
    import nic_regs_pkg::*;
#(
    parameter int unsigned N_RX = 4,
    parameter int unsigned N_TX = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic                   ev_rx,
    input  logic                   ev_txq0,
    input  logic                   ev_txq1,
    output logic                   irq,
    output logic [1:0]             tx_start,
    output logic [1:0]             rx_pad_bytes,
    output logic [N_RX*DATA_W-1:0] rx_first_ptrs,
    output logic [N_RX*DATA_W-1:0] rx_cur_ptrs,
    output logic [N_TX*DATA_W-1:0] tx_cur_ptrs
);
    wr_req_t           wreq;
    logic [DATA_W-1:0] cause, mask, mg_resp, rxf_val, rxc_val, txc_val, rd_mux;
    logic              mg_opc, rxf_hit, rxc_hit, txc_hit, pad_q, any_hit;

    assign wreq = '{en: bus_wr, off: bus_addr, data: bus_wdata};

    nic_cause_ctl u_cause (
        .clk(clk), .rst_n(rst_n),
        .cause_wr(bus_wr && bus_addr == OFF_CAUSE),
        .mask_wr(bus_wr && bus_addr == OFF_MASK),
        .wdata(bus_wdata), .ev_rx(ev_rx), .ev_txq0(ev_txq0), .ev_txq1(ev_txq1),
        .cause(cause), .mask(mask), .irq(irq)
    );

    nic_mgmt_port u_mgmt (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr && bus_addr == OFF_MGMT),
        .wdata(bus_wdata), .opc(mg_opc), .resp(mg_resp)
    );

    nic_ptr_bank #(.N(N_RX), .BASE(int'(OFF_RXFIRST))) u_rxfirst (
        .clk(clk), .rst_n(rst_n), .wr(wreq), .rd_off(bus_addr),
        .rd_hit(rxf_hit), .rd_val(rxf_val), .ptrs(rx_first_ptrs)
    );
    nic_ptr_bank #(.N(N_RX), .BASE(int'(OFF_RXCUR))) u_rxcur (
        .clk(clk), .rst_n(rst_n), .wr(wreq), .rd_off(bus_addr),
        .rd_hit(rxc_hit), .rd_val(rxc_val), .ptrs(rx_cur_ptrs)
    );
    nic_ptr_bank #(.N(N_TX), .BASE(int'(OFF_TXCUR))) u_txcur (
        .clk(clk), .rst_n(rst_n), .wr(wreq), .rd_off(bus_addr),
        .rd_hit(txc_hit), .rd_val(txc_val), .ptrs(tx_cur_ptrs)
    );

    // Read selection over all readable registers; write-only words read 0
    always_comb begin
        rd_mux  = '0;
        any_hit = 1'b1;
        if (bus_addr == OFF_MGMT)       rd_mux = mg_resp;
        else if (bus_addr == OFF_CAUSE) rd_mux = cause;
        else if (bus_addr == OFF_MASK)  rd_mux = mask;
        else if (bus_addr == OFF_PORT || bus_addr == OFF_CMD) rd_mux = '0;
        else if (rxf_hit)               rd_mux = rxf_val;
        else if (rxc_hit)               rd_mux = rxc_val;
        else if (txc_hit)               rd_mux = txc_val;
        else                            any_hit = 1'b0;
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    // Transmit start pulses from command writes; nothing is stored
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_start <= '0;
        else if (bus_wr && bus_addr == OFF_CMD)
            tx_start <= {bus_wdata[CMD_Q1_BIT], bus_wdata[CMD_Q0_BIT]};
        else
            tx_start <= '0;
    end

    // Port setting: two-byte receive offset
    always_ff @(posedge clk) begin
        if (!rst_n)
            pad_q <= 1'b0;
        else if (bus_wr && bus_addr == OFF_PORT)
            pad_q <= bus_wdata[PORT_PAD_BIT];
    end
    assign rx_pad_bytes = pad_q ? 2'd2 : 2'd0;

    AST_IRQ_ON_RX_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx && mask[CAUSE_RX]) |=> irq); // R4
    AST_TXSTART_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start[0] |-> $past(bus_wr && bus_addr == OFF_CMD && bus_wdata[CMD_Q0_BIT])); // R7
    AST_MGMT_VALID_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_MGMT) |=> (bus_rdata[MG_VALID_BIT] == $past(mg_opc))); // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !any_hit) |=> (bus_rdata == '0)); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

// File: tb/sim_nic_ctrl_regs.sv
// Scoreboard bench: reads push expected words into a queue, a monitor
// pops and compares them when the registered read data appears.
module sim_nic_ctrl_regs;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         ev_rx = 1'b0, ev_txq0 = 1'b0, ev_txq1 = 1'b0;
    logic         irq;
    logic [1:0]   tx_start, rx_pad_bytes;
    logic [127:0] rx_first_ptrs, rx_cur_ptrs;
    logic [63:0]  tx_cur_ptrs;

    int n_chk = 0;
    int n_fail = 0;
    logic rd_seen = 1'b0;
    logic [31:0] last_rd;

    typedef struct { string tag; logic [31:0] exp; } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rx(ev_rx), .ev_txq0(ev_txq0), .ev_txq1(ev_txq1), .irq(irq),
        .tx_start(tx_start), .rx_pad_bytes(rx_pad_bytes),
        .rx_first_ptrs(rx_first_ptrs), .rx_cur_ptrs(rx_cur_ptrs),
        .tx_cur_ptrs(tx_cur_ptrs)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one cycle from a falling edge; returns on the next falling edge
    task automatic cyc(input logic wr, input logic rd, input logic [11:0] a,
                       input logic [31:0] d, input logic [2:0] ev);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        {ev_txq1, ev_txq0, ev_rx} = ev;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        {ev_txq1, ev_txq0, ev_rx} = 3'b000;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d, 3'b000);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_t it;
        it.tag = tag; it.exp = exp;
        sb_q.push_back(it);
        cyc(1'b0, 1'b1, a, '0, 3'b000);
    endtask

    // Monitor: read data is valid on the falling edge after the read edge
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            exp_t it;
            if (sb_q.size() == 0) begin
                check("R11 unexpected read data", 1, 0);
            end else begin
                it = sb_q.pop_front();
                check(it.tag, {96'b0, bus_rdata}, {96'b0, it.exp});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 tx_start", tx_start, 0);
        check("R1 pad", rx_pad_bytes, 0);
        check("R1 ptrs", rx_first_ptrs | rx_cur_ptrs | tx_cur_ptrs, 0);
        rd(12'h450, 0, "R1 cause");
        rd(12'h458, 0, "R1 mask");
        rd(12'h010, 0, "R1 mgmt");
        rd(12'h4A4, 0, "R1 rxcur1");

        // R9 ring pointers
        for (int i = 0; i < 4; i++) begin
            wr(12'h480 + 12'(4*i), 32'h1000_0000 + 32'(i*16));
            wr(12'h4A0 + 12'(4*i), 32'h2000_0000 + 32'(i*16));
        end
        for (int i = 0; i < 2; i++) wr(12'h4E0 + 12'(4*i), 32'h3000_0000 + 32'(i*16));
        for (int i = 0; i < 4; i++) begin
            rd(12'h480 + 12'(4*i), 32'h1000_0000 + 32'(i*16), "R9 rxfirst");
            rd(12'h4A0 + 12'(4*i), 32'h2000_0000 + 32'(i*16), "R9 rxcur");
        end
        rd(12'h4E4, 32'h3000_0010, "R9 txcur1");
        check("R9 rxfirst slice2", rx_first_ptrs[95:64], 32'h1000_0020);
        check("R9 txcur slice0", tx_cur_ptrs[31:0], 32'h3000_0000);

        // R5 / R6 management model
        wr(12'h010, 32'h0421_0000); rd(12'h010, 32'h0800_000C, "R5 status");
        wr(12'h010, 32'h0441_0000); rd(12'h010, 32'h0800_0141, "R5 id1");
        wr(12'h010, 32'h0461_FFFF); rd(12'h010, 32'h0800_0E20, "R5 id2");
        wr(12'h010, 32'h0455_0000); rd(12'h010, 32'h0800_0000, "R6 other addr");
        wr(12'h010, 32'h0021_0000); rd(12'h010, 32'h0000_0000, "R6 opcode clear");

        // R2 / R3 / R4 cause and mask
        cyc(1'b0, 1'b0, '0, '0, 3'b001);
        check("R4 masked off", irq, 0);
        rd(12'h450, 32'h1, "R2 rx cause");
        wr(12'h458, 32'h1);
        check("R4 mask write raises irq", irq, 1);
        cyc(1'b0, 1'b0, '0, '0, 3'b110);
        rd(12'h450, 32'hD, "R2 tx causes bits 2,3");
        wr(12'h450, 32'hFFFF_FFFE);
        check("R4 irq drops", irq, 0);
        rd(12'h450, 32'hC, "R2 and-clear");
        cyc(1'b1, 1'b0, 12'h450, 32'h0, 3'b001);
        check("R3 irq after collision", irq, 1);
        rd(12'h450, 32'h1, "R3 event kept");
        wr(12'h450, 32'hFFFF_FFFF);
        rd(12'h450, 32'h1, "R2 ones cannot set");
        rd(12'h458, 32'h1, "R4 mask readback");
        wr(12'h450, 32'h0);
        check("R4 cleared", irq, 0);

        // R7 command strobes
        wr(12'h448, 32'h0040_0000);
        check("R7 q0 pulse", tx_start, 2'b01);
        @(negedge clk);
        check("R7 pulse ends", tx_start, 2'b00);
        wr(12'h448, 32'h0080_0000);
        check("R7 q1 pulse", tx_start, 2'b10);
        wr(12'h448, 32'h00C0_0000);
        check("R7 both", tx_start, 2'b11);
        rd(12'h448, 0, "R7 reads zero");

        // R8 port setting
        wr(12'h408, 32'h1000_0000);
        check("R8 pad on", rx_pad_bytes, 2);
        rd(12'h408, 0, "R8 reads zero");
        wr(12'h408, 32'h0);
        check("R8 pad off", rx_pad_bytes, 0);

        // R10 unmapped offsets
        wr(12'h4E8, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h490, 32'hFFFF_FFFF);
        check("R10 no output change", {tx_start, rx_pad_bytes, irq}, 0);
        check("R10 ptrs intact", tx_cur_ptrs, {32'h3000_0010, 32'h3000_0000});
        rd(12'h4E8, 0, "R10 read 4E8");
        rd(12'h000, 0, "R10 read 000");
        rd(12'h4E4, 32'h3000_0010, "R10 txcur1 kept");
        rd(12'h458, 32'h1, "R10 mask kept");

        // R11 read ordering and hold
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 12'h458; bus_wdata = 32'h5;
        sb_q.push_back('{tag: "R11 read before write", exp: 32'h1});
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        last_rd = bus_rdata;
        repeat (3) @(negedge clk);
        check("R11 hold", bus_rdata, last_rd);
        rd(12'h458, 32'h5, "R11 write landed");

        @(negedge clk);
        check("R11 scoreboard drained", sb_q.size(), 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule